// File: doc/BRIEF.md
# Sample FIFO with Half-Full Interrupt

This block sits between a 12-bit converter and an 8-bit host data bus. Every converted sample that arrives with its valid strobe is stored in a first-in first-out buffer of 256 entries. The host fetches each sample with two byte reads. The low byte carries four status flags in its lower nibble and the lowest four sample bits in its upper nibble. The high byte carries the remaining eight sample bits.

The host need not poll after every conversion. It can enable a level interrupt that is asserted while at least half the buffer is occupied, and then drain a burst of samples. A master convert enable gates the whole block. While it is low the buffer is flushed, the sticky overflow flag is cleared, incoming samples are ignored and every status flag reads zero.

Top module: `sample_fifo_hf`

## Requirements
- R1: Samples are returned in the order they were accepted, with all 12 bits intact, and the buffer holds up to 256 samples.
- R2: The low read byte is {sample[3:0], full, half, overflow, empty}. Bit 0 is empty, bit 1 is overflow, bit 2 is set while 128 or more samples are stored, bit 3 is set while 256 are stored, and bits 7:4 are bits 3:0 of the oldest sample. The high read byte is bits 11:4 of the oldest sample.
- R3: A high-byte read strobe removes the oldest sample only if a low-byte read strobe for that sample came earlier. A high-byte strobe with no earlier low-byte strobe leaves the buffer unchanged.
- R4: Read strobes while the buffer is empty have no effect on its later contents.
- R5: A sample arriving while 256 samples are stored, in a cycle with no removal, is dropped and sets a sticky overflow flag. The stored samples are kept, and the flag stays set while the master enable stays high.
- R6: While the master enable is low, the empty and overflow ports and low-byte bits 3:0 read 0. In that state the buffer is flushed, overflow is cleared and arriving samples are discarded.
- R7: The interrupt request is a level that is high exactly when the master enable, the end-of-conversion interrupt enable and the half-full interrupt enable are all 1 and at least 128 samples are stored. It drops once occupancy falls to 127.
- R8: With the master enable high, the empty port is 1 exactly when no sample is stored, and the overflow port equals low-byte bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Master convert enable |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| hf_ie | input | 1 | Half-full interrupt enable |
| smp_vld | input | 1 | Sample valid strobe |
| smp_data | input | 12 | Converted sample |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe, removes the sample |
| lo_byte | output | 8 | Flags and sample bits 3:0 |
| hi_byte | output | 8 | Sample bits 11:4 |
| irq | output | 1 | Half-full transfer request |
| empty | output | 1 | Buffer empty flag |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A table of eight samples is written and read back. It includes all zeros, all ones, alternating bit patterns and values with only the end nibbles set, which would reveal any swapped, shifted or dropped byte lanes. A full 256-sample fill with distinct values, followed by a complete drain, separates correct pointer wrap and ordering from aliasing errors. The occupancy is stepped across 127 and 128 while each interrupt enable is toggled, to locate the threshold and its gating. Out-of-order strobes, reads while empty, writes while full and a mid-run disable each target one specific corner of the control logic.

// File: rtl/sample_fifo_hf.sv
module sample_fifo_hf #(
  parameter int DEPTH = 256,
  parameter int SW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_en,
  input  logic          eoc_ie,
  input  logic          hf_ie,
  input  logic          smp_vld,
  input  logic [SW-1:0] smp_data,
  input  logic          rd_lo,
  input  logic          rd_hi,
  output logic [7:0]    lo_byte,
  output logic [SW-5:0] hi_byte,
  output logic          irq,
  output logic          empty,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          ovf_q, lo_seen;

  wire is_empty = (cnt == '0);
  wire is_full  = (cnt == FULLC);
  wire is_half  = (cnt >= HALFC);
  wire pop      = conv_en & rd_hi & lo_seen & ~is_empty;
  wire push     = conv_en & smp_vld & (~is_full | pop);
  wire drop     = conv_en & smp_vld & is_full & ~pop;

  wire [SW-1:0] head  = mem[rp];
  wire [3:0]    flags = conv_en ? {is_full, is_half, ovf_q, is_empty} : 4'b0000;

  assign lo_byte = {head[3:0], flags};
  assign hi_byte = head[SW-1:4];
  assign empty   = flags[0];
  assign ovf     = flags[1];
  assign irq     = conv_en & eoc_ie & hf_ie & is_half;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= smp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      ovf_q   <= 1'b0;
      lo_seen <= 1'b0;
    end else if (!conv_en) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      ovf_q   <= 1'b0;
      lo_seen <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (drop) ovf_q <= 1'b1;
      if (pop)                    lo_seen <= 1'b0;
      else if (rd_lo && !is_empty) lo_seen <= 1'b1;
    end
  end

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && conv_en) |=> ovf_q);

  // R6
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> (cnt == '0 && !ovf_q));

  // R3
  hi_needs_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && rd_hi && !lo_seen && !smp_vld) |=> $stable(cnt));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLC);

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < HALFC) |-> !irq);
endmodule

// File: tb/sample_fifo_hf_tb_top.sv
module sample_fifo_hf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_en = 0, eoc_ie = 0, hf_ie = 0, smp_vld = 0, rd_lo = 0, rd_hi = 0;
  logic [11:0] smp_data = '0;
  logic [7:0] lo_byte, hi_byte;
  logic irq, empty, ovf;
  int nvec = 0, nbad = 0;
  logic [11:0] model[$];

  always #10 clk = ~clk;

  sample_fifo_hf dut_i (.clk(clk), .rst_n(rst_n), .conv_en(conv_en), .eoc_ie(eoc_ie),
    .hf_ie(hf_ie), .smp_vld(smp_vld), .smp_data(smp_data), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .lo_byte(lo_byte), .hi_byte(hi_byte), .irq(irq), .empty(empty), .ovf(ovf));

  localparam logic [11:0] VEC [0:7] = '{12'h000, 12'hFFF, 12'h5A5, 12'hA5A,
                                        12'h00F, 12'hF00, 12'h801, 12'h7FE};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [11:0] v);
    @(negedge clk); smp_vld = 1; smp_data = v;
    @(negedge clk); smp_vld = 0;
    if (conv_en && model.size() < 256) model.push_back(v);
  endtask

  task automatic rdpair(output logic [7:0] lo, output logic [7:0] hi);
    @(negedge clk); rd_lo = 1; lo = lo_byte;
    @(negedge clk); rd_lo = 0; rd_hi = 1; hi = hi_byte;
    @(negedge clk); rd_hi = 0;
  endtask

  task automatic rd_model;
    logic [7:0] lo, hi;
    logic [11:0] e;
    e = model.pop_front();
    rdpair(lo, hi);
    chk("R1 order", {lo[7:4], hi}, {e[3:0], e[11:4]});
  endtask

  initial begin
    #(20ns * 190000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset flags", {lo_byte[3:0], empty, ovf, irq}, 7'b0);
    conv_en = 1; eoc_ie = 1; hf_ie = 1;
    @(negedge clk);
    chk("R8 empty after enable", {empty, ovf, lo_byte[3:0]}, 6'b10_0001);

    for (int i = 0; i < 8; i++) push(VEC[i]);
    for (int i = 0; i < 8; i++) begin
      rdpair(lo, hi);
      chk("R2 low byte", lo, {VEC[i][3:0], 4'b0000});
      chk("R2 high byte", hi, VEC[i][11:4]);
      void'(model.pop_front());
    end
    chk("R8 empty after drain", empty, 1);

    push(12'hABC);
    @(negedge clk); rd_hi = 1; @(negedge clk); rd_hi = 0;
    chk("R3 hi without lo keeps sample", empty, 0);
    rd_model();
    chk("R3 pair removes", empty, 1);

    rdpair(lo, hi);
    push(12'h123);
    chk("R4 empty reads no effect", lo_byte[3:0], 4'b0000);
    rd_model();

    for (int i = 0; i < 127; i++) push(12'((i * 37 + 5)));
    chk("R7 irq at 127", irq, 0);
    chk("R2 half flag at 127", lo_byte[2], 0);
    push(12'h3C3);
    chk("R7 irq at 128", irq, 1);
    chk("R2 half flag at 128", lo_byte[2], 1);
    eoc_ie = 0; @(negedge clk);
    chk("R7 irq gated by eoc_ie", irq, 0);
    eoc_ie = 1; hf_ie = 0; @(negedge clk);
    chk("R7 irq gated by hf_ie", irq, 0);
    hf_ie = 1; @(negedge clk);
    rd_model();
    chk("R7 irq drops at 127", irq, 0);
    push(12'h456);
    chk("R7 irq back at 128", irq, 1);

    for (int i = 0; i < 128; i++) push(12'((i * 91 + 11)));
    chk("R2 full flag", {lo_byte[3], ovf}, 2'b10);
    push(12'hFFF);
    chk("R5 overflow set", {ovf, lo_byte[1]}, 2'b11);
    rd_model();
    chk("R5 overflow sticky", ovf, 1);
    while (model.size() > 0) rd_model();
    chk("R8 empty after full drain", empty, 1);

    push(12'h111); push(12'h222);
    conv_en = 0; @(negedge clk);
    chk("R6 disabled flags", {empty, ovf, irq, lo_byte[3:0]}, 7'b0);
    @(negedge clk); smp_vld = 1; smp_data = 12'h999; @(negedge clk); smp_vld = 0;
    conv_en = 1; model.delete(); @(negedge clk);
    chk("R6 flushed and cleared", {empty, ovf}, 2'b10);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule